// File: doc/BRIEF.md
# POST Code Capture Display

This block watches the write side of a simple host I/O bus. Any byte written to one configured I/O address (80h by default) is captured. The captured byte is shown as two hexadecimal digits on a two-digit, time-multiplexed, common-cathode seven-segment display. The byte stays on the display until another write reaches that address. If the host stops part-way through start-up, the display therefore keeps showing the last checkpoint the host reached.

The block also has a failure-report mode, entered through a sideband load port. That port carries a one-byte checkpoint code and a 16-bit failure bitmap; bit n of the bitmap set means line or bit n failed, so 0002h flags bit 1. In this mode the display shows three bytes in a fixed order: the code, then the upper bitmap byte, then the lower bitmap byte. Each byte is held for one programmable pause, and the loop repeats until new data arrives. A plain write to the port ends the loop and returns the block to single-byte display.

Top module: `postcode_display`

## Requirements
- R1: A write (`io_wr`=1) with `io_addr` equal to `PORT_ADDR` captures `io_data`. The captured byte is the displayed byte from the next clock on.
- R2: A write to any other address, or a cycle with `io_wr`=0, leaves the displayed byte unchanged in single-byte mode. The byte is held for as long as no new capture occurs.
- R3: Each digit uses the standard hex glyphs with `seg[0]`=a through `seg[6]`=g, active high: 0=3Fh, 1=06h, 2=5Bh, 3=4Fh, 4=66h, 5=6Dh, 6=7Dh, 7=07h, 8=7Fh, 9=6Fh, A=77h, b=7Ch, C=39h, d=5Eh, E=79h, F=71h.
- R4: `dig_sel` is one-hot and active high. `dig_sel`=01b enables digit 0, which shows the low nibble; `dig_sel`=10b enables digit 1, which shows the high nibble. The enabled digit changes every `SCAN_CYC` clocks.
- R5: A `fail_load` pulse stores `fail_code` and `fail_map` and enters cycling mode. The code is the displayed byte from the next clock on, and the pause timer restarts.
- R6: In cycling mode each step is displayed for exactly `PAUSE_CYC` clocks. The steps run in the order code, `fail_map[15:8]`, `fail_map[7:0]`, then return to the code, without end.
- R7: A capture on the port leaves cycling mode and shows the captured byte. When a capture and `fail_load` occur in the same cycle, the capture wins and the block stays in single-byte mode.
- R8: Synchronous active-high `rst` clears the captured byte to 00h and selects single-byte mode. It also enables digit 0 and restarts both timers.
- R9: A `fail_load` while the block is already cycling restarts the loop at the code step with the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_addr | input | ADDR_W | Host I/O write address |
| io_wr | input | 1 | Host I/O write strobe, one cycle per write |
| io_data | input | 8 | Host I/O write data |
| fail_load | input | 1 | Load failure code and bitmap, start cycling |
| fail_code | input | 8 | Checkpoint code for failure report |
| fail_map | input | 16 | Failure bitmap, bit n set = item n failed |
| seg | output | 7 | Segments a..g, active high |
| dig_sel | output | 2 | One-hot digit enable, bit 1 = high nibble digit |

## Verification
Every result of this block follows a stimulus by exactly one register stage. A capture, a failure load or a reset changes `seg` on the first clock after the input is seen. A phase step occurs exactly `PAUSE_CYC` clocks after the previous step or load, and a digit change exactly `SCAN_CYC` clocks after the previous one. The bench drives its inputs on the falling edge. A behavioural model advances on each rising edge, and `seg` and `dig_sel` are compared against that model on every falling edge. This places each expected change in the cycle it is due in, with no tolerance window. Short pause and scan periods let the bench see several full loops, mid-loop reloads and cancels.

// File: rtl/postcode_pkg.sv
package postcode_pkg;

    typedef enum logic [1:0] {
        PH_CODE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_e;

    // a..g on bits 0..6, active high
    function automatic logic [6:0] hex_glyph(input logic [3:0] nib);
        logic [6:0] g;
        case (nib)
            4'h0: g = 7'h3F;
            4'h1: g = 7'h06;
            4'h2: g = 7'h5B;
            4'h3: g = 7'h4F;
            4'h4: g = 7'h66;
            4'h5: g = 7'h6D;
            4'h6: g = 7'h7D;
            4'h7: g = 7'h07;
            4'h8: g = 7'h7F;
            4'h9: g = 7'h6F;
            4'hA: g = 7'h77;
            4'hB: g = 7'h7C;
            4'hC: g = 7'h39;
            4'hD: g = 7'h5E;
            4'hE: g = 7'h79;
            default: g = 7'h71;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/postcode_pacer.sv
module postcode_pacer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    output logic wrap
);
    localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        wrap  = run && (cnt_q == LAST);
        if (clear) begin
            cnt_d = '0;
        end else if (run) begin
            cnt_d = wrap ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/postcode_seq.sv
module postcode_seq
    import postcode_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        port_hit,
    input  logic [7:0]  wr_byte,
    input  logic        fail_load,
    input  logic [7:0]  fail_code,
    input  logic [15:0] fail_map,
    input  logic        step,
    output logic        cyc_mode,
    output phase_e      phase,
    output logic [7:0]  shown
);
    typedef struct packed {
        logic [7:0]  latch;
        logic [7:0]  code;
        logic [15:0] map;
        logic        cyc;
        phase_e      ph;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (port_hit) begin
            s_d.latch = wr_byte;
            s_d.cyc   = 1'b0;
        end else if (fail_load) begin
            s_d.code = fail_code;
            s_d.map  = fail_map;
            s_d.cyc  = 1'b1;
            s_d.ph   = PH_CODE;
        end else if (s_q.cyc && step) begin
            case (s_q.ph)
                PH_CODE: s_d.ph = PH_HIGH;
                PH_HIGH: s_d.ph = PH_LOW;
                default: s_d.ph = PH_CODE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.latch <= '0;
            s_q.code  <= '0;
            s_q.map   <= '0;
            s_q.cyc   <= 1'b0;
            s_q.ph    <= PH_CODE;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        if (!s_q.cyc) begin
            shown = s_q.latch;
        end else begin
            case (s_q.ph)
                PH_CODE: shown = s_q.code;
                PH_HIGH: shown = s_q.map[15:8];
                default: shown = s_q.map[7:0];
            endcase
        end
    end

    assign cyc_mode = s_q.cyc;
    assign phase    = s_q.ph;
endmodule

// File: rtl/postcode_digit_drv.sv
module postcode_digit_drv
    import postcode_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       flip,
    input  logic [7:0] value,
    output logic [6:0] seg,
    output logic [1:0] dig_sel
);
    logic dig_d, dig_q;

    always_comb begin
        dig_d = flip ? ~dig_q : dig_q;
    end

    always_ff @(posedge clk) begin
        if (rst) dig_q <= 1'b0;
        else     dig_q <= dig_d;
    end

    assign seg     = hex_glyph(dig_q ? value[7:4] : value[3:0]);
    assign dig_sel = dig_q ? 2'b10 : 2'b01;
endmodule

// File: rtl/postcode_display.sv
module postcode_display
    import postcode_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 'h80,
    parameter int              PAUSE_CYC = 1 << 24,
    parameter int              SCAN_CYC  = 1 << 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic [7:0]        io_data,
    input  logic              fail_load,
    input  logic [7:0]        fail_code,
    input  logic [15:0]       fail_map,
    output logic [6:0]        seg,
    output logic [1:0]        dig_sel
);
    logic       port_hit;
    logic       step;
    logic       flip;
    logic       cyc_mode;
    phase_e     phase;
    logic [7:0] shown;

    assign port_hit = io_wr && (io_addr == PORT_ADDR);

    postcode_pacer #(.LIMIT(PAUSE_CYC)) u_pause (
        .clk   (clk),
        .rst   (rst),
        .clear (port_hit | fail_load),
        .run   (cyc_mode),
        .wrap  (step)
    );

    postcode_pacer #(.LIMIT(SCAN_CYC)) u_scan (
        .clk   (clk),
        .rst   (rst),
        .clear (1'b0),
        .run   (1'b1),
        .wrap  (flip)
    );

    postcode_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .port_hit  (port_hit),
        .wr_byte   (io_data),
        .fail_load (fail_load),
        .fail_code (fail_code),
        .fail_map  (fail_map),
        .step      (step),
        .cyc_mode  (cyc_mode),
        .phase     (phase),
        .shown     (shown)
    );

    postcode_digit_drv u_drv (
        .clk     (clk),
        .rst     (rst),
        .flip    (flip),
        .value   (shown),
        .seg     (seg),
        .dig_sel (dig_sel)
    );
endmodule

// File: rtl/postcode_display_chk.sv
module postcode_display_chk
    import postcode_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 'h80
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_wr,
    input logic [7:0]        io_data,
    input logic              fail_load,
    input logic [7:0]        fail_code,
    input logic [6:0]        seg,
    input logic [1:0]        dig_sel,
    input logic              cyc_mode,
    input phase_e            phase,
    input logic [7:0]        shown
);
    logic hit;
    assign hit = io_wr && (io_addr == PORT_ADDR);

    // R1
    capture_shown_chk: assert property (@(posedge clk) disable iff (rst)
        hit |=> (shown == $past(io_data)) && !cyc_mode);

    // R2
    hold_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (!hit && !fail_load && !cyc_mode) |=> $stable(shown));

    // R3
    glyph_lit_chk: assert property (@(posedge clk) disable iff (rst)
        seg != 7'h00);

    // R4
    digit_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(dig_sel) == 1);

    // R5
    fail_enter_chk: assert property (@(posedge clk) disable iff (rst)
        (fail_load && !hit) |=> cyc_mode && (shown == $past(fail_code)) && (phase == PH_CODE));

    // R6
    phase_order_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_mode && !hit && !fail_load && phase == PH_LOW) |=> (phase == PH_LOW || phase == PH_CODE));

    // R7
    cancel_cyc_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && fail_load) |=> !cyc_mode);

    // R8
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (shown == 8'h00) && !cyc_mode && (dig_sel == 2'b01));
endmodule

bind postcode_display postcode_display_chk #(
    .ADDR_W    (ADDR_W),
    .PORT_ADDR (PORT_ADDR)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .io_addr   (io_addr),
    .io_wr     (io_wr),
    .io_data   (io_data),
    .fail_load (fail_load),
    .fail_code (fail_code),
    .seg       (seg),
    .dig_sel   (dig_sel),
    .cyc_mode  (cyc_mode),
    .phase     (phase),
    .shown     (shown)
);

// File: tb/sim_postcode_display.sv
`timescale 1ns/1ps
module sim_postcode_display;
    localparam int P = 5;
    localparam int S = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_data = '0;
    logic        fail_load = 1'b0;
    logic [7:0]  fail_code = '0;
    logic [15:0] fail_map = '0;
    logic [6:0]  seg;
    logic [1:0]  dig_sel;

    always #2 clk = ~clk;

    postcode_display #(
        .ADDR_W(16), .PORT_ADDR(16'h0080), .PAUSE_CYC(P), .SCAN_CYC(S)
    ) u0 (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_data(io_data),
        .fail_load(fail_load), .fail_code(fail_code), .fail_map(fail_map),
        .seg(seg), .dig_sel(dig_sel)
    );

    int checks = 0;
    int errors = 0;
    string cur_req = "R8";
    bit started = 0;
    bit done = 0;

    function automatic logic [6:0] glyph(input int n);
        case (n & 15)
            0: return 7'h3F;  1: return 7'h06;  2: return 7'h5B;  3: return 7'h4F;
            4: return 7'h66;  5: return 7'h6D;  6: return 7'h7D;  7: return 7'h07;
            8: return 7'h7F;  9: return 7'h6F;  10: return 7'h77; 11: return 7'h7C;
            12: return 7'h39; 13: return 7'h5E; 14: return 7'h79; default: return 7'h71;
        endcase
    endfunction

    // behavioural reference
    int m_latch, m_code, m_map, m_cyc, m_phase, m_pcnt, m_scnt, m_dig;

    function automatic int m_byte();
        if (m_cyc == 0) return m_latch;
        if (m_phase == 0) return m_code;
        if (m_phase == 1) return (m_map >> 8) & 255;
        return m_map & 255;
    endfunction

    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) begin
            m_latch = 0; m_code = 0; m_map = 0; m_cyc = 0;
            m_phase = 0; m_pcnt = 0; m_scnt = 0; m_dig = 0;
        end else begin
            if (io_wr && io_addr == 16'h0080) begin
                m_latch = io_data; m_cyc = 0; m_pcnt = 0;
            end else if (fail_load) begin
                m_code = fail_code; m_map = fail_map; m_cyc = 1; m_phase = 0; m_pcnt = 0;
            end else if (m_cyc != 0) begin
                if (m_pcnt == P - 1) begin
                    m_pcnt = 0; m_phase = (m_phase + 1) % 3;
                end else m_pcnt++;
            end
            if (m_scnt == S - 1) begin
                m_scnt = 0; m_dig ^= 1;
            end else m_scnt++;
        end
    end

    always @(negedge clk) begin
        if (started && !done) begin
            logic [6:0] es;
            logic [1:0] ed;
            ed = (m_dig != 0) ? 2'b10 : 2'b01;
            es = glyph((m_dig != 0) ? (m_byte() >> 4) : m_byte());
            checks++;
            if (dig_sel !== ed) begin
                errors++;
                $display("FAIL R4 dig_sel act=%b exp=%b t=%0t", dig_sel, ed, $time);
            end
            checks++;
            if (seg !== es) begin
                errors++;
                $display("FAIL %s seg act=%h exp=%h t=%0t", cur_req, seg, es, $time);
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic port_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_data = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic load_fail(input logic [7:0] c, input logic [15:0] m);
        @(negedge clk);
        fail_code = c; fail_map = m; fail_load = 1'b1;
        @(negedge clk);
        fail_load = 1'b0;
    endtask

    // sample the DUT display for a full scan of both digits and compare to a byte
    task automatic peek_byte(input string tag, input int exp);
        for (int i = 0; i < 2 * S; i++) begin
            int nib;
            nib = (dig_sel == 2'b10) ? (exp >> 4) : exp;
            check(tag, seg, glyph(nib));
            @(negedge clk);
        end
    endtask

    initial begin
        cycles(3);
        rst = 1'b0;
        // R8: reset state
        check("R8 dig_sel", dig_sel, 2'b01);
        check("R8 seg", seg, glyph(0));

        cur_req = "R1";
        port_write(16'h0080, 8'hA5);
        peek_byte("R1 A5", 8'hA5);
        port_write(16'h0080, 8'h3C);
        port_write(16'h0080, 8'h16);
        peek_byte("R1 16", 8'h16);

        cur_req = "R2";
        port_write(16'h0081, 8'hEE);
        port_write(16'h0180, 8'h77);
        @(negedge clk); io_addr = 16'h0080; io_data = 8'h99; io_wr = 1'b0;
        cycles(40);
        peek_byte("R2 hold", 8'h16);

        cur_req = "R3";
        for (int v = 0; v < 16; v++) begin
            port_write(16'h0080, 8'(v * 17));
            peek_byte("R3 glyph", v * 17);
        end

        cur_req = "R4";
        port_write(16'h0080, 8'hF0);
        cycles(4 * S);

        cur_req = "R5";
        load_fail(8'h2C, 16'h0002);
        check("R5 code shown", seg, glyph((dig_sel == 2'b10) ? 8'h2C >> 4 : 8'h2C));

        cur_req = "R6";
        cycles(9 * P + 2);

        cur_req = "R9";
        load_fail(8'h2E, 16'h1020);
        check("R9 restart", seg, glyph((dig_sel == 2'b10) ? 8'h2E >> 4 : 8'h2E));
        cycles(P + 2);
        load_fail(8'h30, 16'hBEEF);
        cycles(7 * P);

        cur_req = "R7";
        port_write(16'h0080, 8'h42);
        peek_byte("R7 cancel", 8'h42);
        cycles(3 * P);
        load_fail(8'h55, 16'hAAAA);
        cycles(P);
        @(negedge clk);
        io_addr = 16'h0080; io_data = 8'hC3; io_wr = 1'b1;
        fail_code = 8'h11; fail_map = 16'h2233; fail_load = 1'b1;
        @(negedge clk);
        io_wr = 1'b0; fail_load = 1'b0;
        peek_byte("R7 same cycle", 8'hC3);
        cycles(3 * P);

        cur_req = "R8";
        load_fail(8'hD2, 16'h8001);
        cycles(P + 1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R8 mid-cycle reset dig", dig_sel, 2'b01);
        check("R8 mid-cycle reset seg", seg, glyph(0));
        cycles(3 * P);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule